// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block is the slave side of a serial memory reached over an SPI bus in mode 0. It holds a 512-byte array, kept in ordinary registers in place of nonvolatile cells. The host selects the block with an active-low select, shifts in an 8-bit instruction and then any address and data, and reads results back on the serial output. The ninth address bit is carried in bit 3 of the read and write instructions. A write-enable latch, a status byte and a timed internal write cycle guard every change to the array or to the status bits.

All pins are sampled in a faster system clock. Edges of the serial clock and of the select are detected in that domain. Writes are gathered in a 4-byte page buffer and applied only when the select rises on a legal byte boundary. The array is then updated once a programmable tick count has elapsed. The status byte also sets which upper region of the array is locked. A 2-bit watchdog-interval field from it is exported for a supervisor elsewhere on the chip.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset, `miso_oe` is 0, `wdog_mode` is 00, and a read-status command returns 0x00.
- R2: A command session opens only on a high-to-low edge of `cs_n`. Clocks given while `cs_n` has been low since reset are ignored. `miso_oe` is 0 whenever `cs_n` is high.
- R3: Instruction codes, MSB first: 0x06 sets the write-enable latch, 0x04 clears it, 0x05 reads status, 0x01 writes status, 0000_A011 reads memory and 0000_A010 writes memory. The status byte reads {2'b00, watchdog[1:0], protect[1:0], write-enable, write-in-progress}.
- R4: The latch is set only when `cs_n` rises after exactly 8 clocks of a 0x06 session. If more clocks follow in the same session, the latch is not set.
- R5: A memory write or status write issued while the latch is clear changes nothing.
- R6: A page write stores consecutive bytes at increasing addresses within one 4-byte page. Past the page's last byte, the next byte goes to the page's first byte.
- R7: A memory write commits only if `cs_n` rises after exactly 24, 32, 40 or 48 clocks, and a status write only after exactly 16. Otherwise the session is discarded and the latch stays set.
- R8: Bit 3 of a read or write instruction is address bit 8, so 0x0A/0x0B reach 0x100–0x1FF and 0x02/0x03 reach 0x000–0x0FF.
- R9: After a read instruction and its address byte, bytes stream out from increasing addresses for as long as clocks continue. The address wraps from 0x1FF to 0x000.
- R10: For WR_TICKS system clocks after a commit, status reads 0xFF and every other command is ignored. At the end the array or status is updated and the latch is cleared.
- R11: Protect field 01 locks 0x180–0x1FF, 10 locks 0x100–0x1FF, 11 locks the whole array, and 00 locks nothing. Bytes in a locked range are skipped by a write. Reads are never blocked.
- R12: A committed status write updates the watchdog field (status bits 5:4) and the protect field (bits 3:2). `wdog_mode` shows the watchdog field.
- R13: `wp_n` low clears the latch, so a pending write loses its commit. `wp_n` low after a write cycle has started does not stop that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4 times the serial clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data in, sampled on rising `sck` |
| wp_n | input | 1 | Write protect, active low |
| miso | output | 1 | Serial data out, changes after falling `sck` |
| miso_oe | output | 1 | Output enable for the `miso` pad driver |
| wdog_mode | output | 2 | Watchdog interval field from the status byte |

## Verification
The write path is tried with single bytes, a full page started mid-page so that it wraps, sessions cut three clocks past a byte boundary, and writes without the latch. Together these separate commit-on-boundary, page wrap and latch gating. Reads are tried at both halves of the array and across the top address, which separates the opcode-borne ninth bit from the streaming wrap. Further patterns are issued during a write cycle (status read, a second write), toggle write protect before and after a commit, and lock the top quarter. These tell apart busy masking, the latch-abort rule and the protect decode.

// File: rtl/eeprom_pkg.sv
// Shared types and helpers for the serial EEPROM slave.
// Assumes a 9-bit byte address; bit 8 travels inside the instruction.
package eeprom_pkg;

    localparam int ADDR_W = 9;

    localparam logic [7:0] INS_WEN_SET = 8'h06;
    localparam logic [7:0] INS_WEN_CLR = 8'h04;
    localparam logic [7:0] INS_STAT_RD = 8'h05;
    localparam logic [7:0] INS_STAT_WR = 8'h01;

    typedef enum logic [2:0] {
        CMD_NONE, CMD_WEN_SET, CMD_WEN_CLR, CMD_STAT_RD,
        CMD_STAT_WR, CMD_MEM_RD, CMD_MEM_WR
    } cmd_e;

    // Map an instruction byte to a command; only status read is allowed while busy.
    function automatic cmd_e decode_cmd(input logic [7:0] ins, input logic busy);
        cmd_e c;
        c = CMD_NONE;
        if (ins == INS_STAT_RD)                         c = CMD_STAT_RD;
        else if (busy)                                  c = CMD_NONE;
        else if (ins == INS_WEN_SET)                    c = CMD_WEN_SET;
        else if (ins == INS_WEN_CLR)                    c = CMD_WEN_CLR;
        else if (ins == INS_STAT_WR)                    c = CMD_STAT_WR;
        else if (ins[7:4] == 4'h0 && ins[2:0] == 3'b011) c = CMD_MEM_RD;
        else if (ins[7:4] == 4'h0 && ins[2:0] == 3'b010) c = CMD_MEM_WR;
        return c;
    endfunction

    // True when the address falls in the region locked by the protect field.
    function automatic logic is_locked(input logic [ADDR_W-1:0] a, input logic [1:0] prot);
        logic r;
        case (prot)
            2'b00:   r = 1'b0;
            2'b01:   r = (a[ADDR_W-1:ADDR_W-2] == 2'b11);
            2'b10:   r = a[ADDR_W-1];
            default: r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
// Synchronizes the serial pins into the system clock and flags edges.
// Assumes clk runs at least 4x sck so each sck level lasts 2+ clocks.
// Flops reset low, so a select held low through reset gives no open edge.
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic wp_n,
    output logic sel_open,
    output logic sel_close,
    output logic sck_rise,
    output logic sck_fall,
    output logic si_s,
    output logic wp_ok
);
    localparam int NPIN = 4;

    logic [NPIN-1:0] pipe [STAGES];
    logic [NPIN-1:0] last;
    logic [NPIN-1:0] now;

    // Synchronizer chain plus one stage of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
            last <= '0;
        end else begin
            pipe[0] <= {wp_n, si, sck, cs_n};
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            last <= pipe[STAGES-1];
        end
    end

    assign now       = pipe[STAGES-1];
    assign sel_open  = last[0] & ~now[0];
    assign sel_close = ~last[0] & now[0];
    assign sck_rise  = now[1] & ~last[1];
    assign sck_fall  = ~now[1] & last[1];
    assign si_s      = now[2];
    assign wp_ok     = now[3];

endmodule

// File: rtl/eeprom_store.sv
// Byte array standing in for the nonvolatile cells.
// One asynchronous read port; a page-wide write with a per-lane enable.
// Assumes lanes never alias, as each lane owns one low-address value.
module eeprom_store #(
    parameter int PAGE_BYTES = 4
) (
    input  logic                                   clk,
    input  logic [eeprom_pkg::ADDR_W-1:0]          rd_addr,
    output logic [7:0]                             rd_data,
    input  logic [eeprom_pkg::ADDR_W-$clog2(PAGE_BYTES)-1:0] wr_page,
    input  logic [PAGE_BYTES-1:0]                  wr_en,
    input  logic [PAGE_BYTES*8-1:0]                wr_data
);
    localparam int LB    = $clog2(PAGE_BYTES);
    localparam int DEPTH = 1 << eeprom_pkg::ADDR_W;

    logic [7:0] cells [DEPTH];

    // Apply every enabled lane of the committed page in one clock.
    always_ff @(posedge clk) begin
        for (int i = 0; i < PAGE_BYTES; i++) begin
            if (wr_en[i]) cells[{wr_page, LB'(i)}] <= wr_data[i*8 +: 8];
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/eeprom_ctrl.sv
// Serial command engine: counts clocks, decodes instructions, buffers a
// page, runs the timed write cycle and shifts out read data and status.
// Assumes single-cycle edge pulses from spi_pin_sync and that sck rise
// and fall never share a clock.
module eeprom_ctrl
    import eeprom_pkg::*;
#(
    parameter int PAGE_BYTES = 4,
    parameter int WR_TICKS   = 200
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sel_open,
    input  logic                       sel_close,
    input  logic                       sck_rise,
    input  logic                       sck_fall,
    input  logic                       si_s,
    input  logic                       wp_ok,
    output logic                       so_bit,
    output logic                       so_en,
    output logic [1:0]                 wdog_mode,
    output logic [ADDR_W-1:0]          rd_addr,
    input  logic [7:0]                 rd_data,
    output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] wr_page,
    output logic [PAGE_BYTES-1:0]      wr_en,
    output logic [PAGE_BYTES*8-1:0]    wr_data
);
    localparam int LB      = $clog2(PAGE_BYTES);
    localparam int MAXBITS = 16 + 8 * PAGE_BYTES;
    localparam int CW      = $clog2(MAXBITS + 2);
    localparam int TW      = $clog2(WR_TICKS + 1);

    logic                         sel;
    logic [CW-1:0]                bitcnt;
    logic [2:0]                   bpos;
    logic [6:0]                   sh;
    cmd_e                         cmd;
    logic                         a8;
    logic [ADDR_W-1:0]            addr;
    logic [LB-1:0]                wptr;
    logic [PAGE_BYTES-1:0][7:0]   pbuf;
    logic [PAGE_BYTES-1:0]        pval;
    logic [7:0]                   pend_sr;
    logic [7:0]                   obuf;
    logic                         out_act;
    logic                         wel;
    logic                         busy;
    logic [TW-1:0]                tcnt;
    logic                         ck_mem;
    logic                         ck_sr;
    logic [1:0]                   wd;
    logic [1:0]                   prot;

    logic [7:0] nb;
    logic       byte_done;
    logic       boundary;
    logic       len_ok;
    logic       go_mem;
    logic       go_sr;
    logic       wen_ok;
    logic       done;
    logic [7:0] stat;
    cmd_e       dec;

    assign nb        = {sh, si_s};
    assign byte_done = sel && sck_rise && (bpos == 3'd7);
    assign boundary  = (bpos == 3'd0) && (bitcnt != '0);
    assign dec       = decode_cmd(nb, busy);
    assign len_ok    = (bitcnt >= CW'(24)) && (bitcnt <= CW'(MAXBITS)) && (bitcnt[2:0] == 3'd0);
    assign go_mem    = sel && sel_close && cmd == CMD_MEM_WR && len_ok && wel && wp_ok && !busy;
    assign go_sr     = sel && sel_close && cmd == CMD_STAT_WR && bitcnt == CW'(16) && wel && wp_ok && !busy;
    assign wen_ok    = sel && sel_close && cmd == CMD_WEN_SET && bitcnt == CW'(8) && !busy;
    assign done      = busy && (tcnt == TW'(WR_TICKS - 1));
    assign stat      = busy ? 8'hFF : {2'b00, wd, prot, wel, 1'b0};

    // Session framing, clock counting, input shifting and header capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= 1'b0; bitcnt <= '0; bpos <= '0; sh <= '0; cmd <= CMD_NONE;
            a8 <= 1'b0; addr <= '0; wptr <= '0; pbuf <= '0; pval <= '0; pend_sr <= '0;
        end else if (sel_open) begin
            sel <= 1'b1; bitcnt <= '0; bpos <= '0; cmd <= CMD_NONE;
        end else if (sel_close) begin
            sel <= 1'b0;
        end else if (sel && sck_rise) begin
            if (bitcnt != '1) bitcnt <= bitcnt + 1'b1;
            bpos <= bpos + 3'd1;
            sh   <= nb[6:0];
            if (byte_done) begin
                if (bitcnt == CW'(7)) begin
                    cmd <= dec;
                    a8  <= nb[3];
                    if (dec == CMD_MEM_WR) pval <= '0;
                end else if (bitcnt == CW'(15)) begin
                    if (cmd == CMD_MEM_RD || cmd == CMD_MEM_WR) begin
                        addr <= {a8, nb};
                        wptr <= nb[LB-1:0];
                    end
                    if (cmd == CMD_STAT_WR) pend_sr <= nb;
                end else if (cmd == CMD_MEM_WR && bitcnt < CW'(MAXBITS)) begin
                    pbuf[wptr] <= nb;
                    pval[wptr] <= 1'b1;
                    wptr       <= wptr + 1'b1;
                end
            end
        end else if (sel && sck_fall && boundary && cmd == CMD_MEM_RD && bitcnt >= CW'(16)) begin
            addr <= addr + 1'b1;
        end
    end

    // Output shifter: loads status or array bytes at each byte boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            obuf <= '0; out_act <= 1'b0;
        end else if (sel_open || sel_close) begin
            out_act <= 1'b0;
        end else if (sel && sck_fall) begin
            if (boundary && cmd == CMD_STAT_RD) begin
                obuf <= stat; out_act <= 1'b1;
            end else if (boundary && cmd == CMD_MEM_RD && bitcnt >= CW'(16)) begin
                obuf <= rd_data; out_act <= 1'b1;
            end else begin
                obuf <= {obuf[6:0], 1'b0};
            end
        end
    end

    // Write-enable latch: protect pin and cycle end clear it first.
    always_ff @(posedge clk) begin
        if (!rst_n)                                           wel <= 1'b0;
        else if (!wp_ok || done)                              wel <= 1'b0;
        else if (wen_ok)                                      wel <= 1'b1;
        else if (byte_done && bitcnt == CW'(7) && dec == CMD_WEN_CLR) wel <= 1'b0;
    end

    // Timed internal write cycle and the status fields it updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; tcnt <= '0; ck_mem <= 1'b0; ck_sr <= 1'b0; wd <= '0; prot <= '0;
        end else if (go_mem || go_sr) begin
            busy <= 1'b1; tcnt <= '0; ck_mem <= go_mem; ck_sr <= go_sr;
        end else if (done) begin
            busy <= 1'b0;
            if (ck_sr) begin
                wd   <= pend_sr[5:4];
                prot <= pend_sr[3:2];
            end
        end else if (busy) begin
            tcnt <= tcnt + 1'b1;
        end
    end

    // Per-lane commit enables, skipping bytes in the locked region.
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
        assign wr_en[g] = done && ck_mem && pval[g] &&
                          !is_locked({addr[ADDR_W-1:LB], LB'(g)}, prot);
    end

    assign wr_page   = addr[ADDR_W-1:LB];
    assign wr_data   = pbuf;
    assign rd_addr   = addr;
    assign so_bit    = obuf[7];
    assign so_en     = sel && out_act;
    assign wdog_mode = wd;

    AST_COMMIT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wel)); // R5
    AST_COMMIT_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(sel_close)); // R7
    AST_WEL_CLEARED_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel); // R10
    AST_WP_DROPS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_ok |=> !wel); // R13
    AST_STREAM_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && sck_fall && !busy && cmd == CMD_MEM_RD && boundary && bitcnt >= CW'(16))
        |=> addr == $past(addr) + 1'b1); // R9

endmodule

// File: rtl/spi_eeprom_slave.sv
// Top of the serial EEPROM slave: pin synchronizer, command engine and
// byte array. Assumes clk is at least 4x sck and the pad driver uses
// miso_oe to float miso while deselected.
module spi_eeprom_slave #(
    parameter int WR_TICKS    = 200,
    parameter int PAGE_BYTES  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       mosi,
    input  logic       wp_n,
    output logic       miso,
    output logic       miso_oe,
    output logic [1:0] wdog_mode
);
    localparam int LB = $clog2(PAGE_BYTES);

    logic sel_open, sel_close, sck_rise, sck_fall, si_s, wp_ok;
    logic [eeprom_pkg::ADDR_W-1:0]    rd_addr;
    logic [7:0]                       rd_data;
    logic [eeprom_pkg::ADDR_W-LB-1:0] wr_page;
    logic [PAGE_BYTES-1:0]            wr_en;
    logic [PAGE_BYTES*8-1:0]          wr_data;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(mosi), .wp_n(wp_n),
        .sel_open(sel_open), .sel_close(sel_close), .sck_rise(sck_rise),
        .sck_fall(sck_fall), .si_s(si_s), .wp_ok(wp_ok)
    );

    eeprom_ctrl #(.PAGE_BYTES(PAGE_BYTES), .WR_TICKS(WR_TICKS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sel_open(sel_open), .sel_close(sel_close),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s), .wp_ok(wp_ok),
        .so_bit(miso), .so_en(miso_oe), .wdog_mode(wdog_mode),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_page(wr_page), .wr_en(wr_en), .wr_data(wr_data)
    );

    eeprom_store #(.PAGE_BYTES(PAGE_BYTES)) u_store (
        .clk(clk), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_page(wr_page), .wr_en(wr_en), .wr_data(wr_data)
    );

endmodule

// File: tb/spi_eeprom_slave_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module spi_eeprom_slave_tb_top;
    localparam int HALF  = 6;
    localparam int TICKS = 1000;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b0, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1;
    logic miso, miso_oe;
    logic [1:0] wdog_mode;
    int checks = 0, failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    spi_eeprom_slave #(.WR_TICKS(TICKS)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .wp_n(wp_n),
        .miso(miso), .miso_oe(miso_oe), .wdog_mode(wdog_mode)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int b = 7; b >= 0; b--) begin
            mosi = tx[b];
            wt(HALF);
            rx[b] = miso;
            sck = 1'b1;
            wt(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic open_s();  cs_n = 1'b0; wt(HALF); endtask
    task automatic close_s(); wt(HALF); cs_n = 1'b1; wt(2 * HALF); endtask

    task automatic extra_bits(input int n);
        for (int i = 0; i < n; i++) begin
            mosi = 1'b1; wt(HALF); sck = 1'b1; wt(HALF); sck = 1'b0;
        end
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] d;
        open_s(); xfer(op, d); close_s();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] d;
        open_s(); xfer(8'h05, d); xfer(8'h00, s); close_s();
    endtask

    task automatic mem_write(input logic [8:0] a, input int n, input logic [31:0] data,
                             input int extra, input bit wp_glitch);
        logic [7:0] d;
        open_s();
        xfer({4'h0, a[8], 3'b010}, d);
        xfer(a[7:0], d);
        for (int i = 0; i < n; i++) xfer(data[31 - 8*i -: 8], d);
        extra_bits(extra);
        if (wp_glitch) begin wp_n = 1'b0; wt(10); wp_n = 1'b1; wt(4); end
        close_s();
    endtask

    task automatic mem_read(input logic [8:0] a, input int n, output logic [31:0] data);
        logic [7:0] d;
        data = '0;
        open_s();
        xfer({4'h0, a[8], 3'b011}, d);
        xfer(a[7:0], d);
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, d);
            data[31 - 8*i -: 8] = d;
        end
        close_s();
    endtask

    task automatic wait_wc(); wt(TICKS + 40); endtask

    task automatic clean_write(input logic [8:0] a, input logic [7:0] v);
        cmd1(8'h06);
        mem_write(a, 1, {v, 24'h0}, 0, 0);
        wait_wc();
    endtask

    task automatic t_reset_and_powerup();
        logic [7:0] s, d;
        wt(5); rst_n = 1'b1; wt(5);
        chk("R1 oe after reset", miso_oe, 0);
        chk("R1 wdog after reset", wdog_mode, 0);
        // select held low since reset: no opening edge, so no command
        xfer(8'h06, d); wt(HALF); cs_n = 1'b1; wt(2 * HALF);
        chk("R2 oe while deselected", miso_oe, 0);
        rdsr(s);
        chk("R2 set-enable without opening edge ignored", s, 8'h00);
        chk("R1 status after reset", s, 8'h00);
    endtask

    task automatic t_latch();
        logic [7:0] s, d;
        cmd1(8'h06); rdsr(s);
        chk("R4 latch set by 8-clock set-enable", s, 8'h02);
        cmd1(8'h04); rdsr(s);
        chk("R3 clear-enable clears latch", s, 8'h00);
        open_s(); xfer(8'h06, d); extra_bits(3); close_s(); rdsr(s);
        chk("R4 latch not set with extra clocks", s, 8'h00);
    endtask

    task automatic t_no_latch();
        logic [31:0] r;
        clean_write(9'h005, 8'h66);
        mem_read(9'h005, 1, r);
        chk("R3 byte write and read back", r[31:24], 8'h66);
        mem_write(9'h005, 1, {8'h99, 24'h0}, 0, 0);
        wait_wc();
        mem_read(9'h005, 1, r);
        chk("R5 write without latch ignored", r[31:24], 8'h66);
    endtask

    task automatic t_page_wrap();
        logic [7:0]  s;
        logic [31:0] r;
        cmd1(8'h06);
        mem_write(9'h0A2, 4, 32'h11223344, 0, 0);
        rdsr(s);
        chk("R10 status all ones while busy", s, 8'hFF);
        wait_wc();
        mem_read(9'h0A0, 4, r);
        chk("R6 page wraps to first byte", r, 32'h33441122);
    endtask

    task automatic t_bad_length();
        logic [7:0]  s;
        logic [31:0] r;
        clean_write(9'h040, 8'h12);
        cmd1(8'h06);
        mem_write(9'h040, 1, {8'h5E, 24'h0}, 3, 0);
        rdsr(s);
        chk("R7 off-boundary close: no cycle, latch kept", s, 8'h02);
        cmd1(8'h04);
        mem_read(9'h040, 1, r);
        chk("R7 off-boundary close discards data", r[31:24], 8'h12);
    endtask

    task automatic t_high_bit_and_stream();
        logic [31:0] r;
        clean_write(9'h1F0, 8'hA5);
        clean_write(9'h0F0, 8'h5A);
        mem_read(9'h1F0, 1, r);
        chk("R8 upper half via opcode bit 3", r[31:24], 8'hA5);
        mem_read(9'h0F0, 1, r);
        chk("R8 lower half via opcode bit 3", r[31:24], 8'h5A);
        clean_write(9'h1FF, 8'h3C);
        clean_write(9'h000, 8'hC3);
        mem_read(9'h1FF, 2, r);
        chk("R9 stream wraps 0x1FF to 0x000", r[31:16], 16'h3CC3);
        mem_read(9'h0A0, 3, r);
        chk("R9 stream auto-increments", r[31:8], 24'h334411);
    endtask

    task automatic t_busy_masking();
        logic [7:0]  s;
        logic [31:0] r;
        cmd1(8'h06);
        mem_write(9'h020, 2, 32'h01020000, 0, 0);
        wait_wc();
        cmd1(8'h06);
        mem_write(9'h020, 1, {8'h5A, 24'h0}, 0, 0);
        mem_write(9'h021, 1, {8'h77, 24'h0}, 0, 0);
        rdsr(s);
        chk("R10 busy status", s, 8'hFF);
        wait_wc();
        mem_read(9'h020, 2, r);
        chk("R10 write during cycle ignored", r[31:16], 16'h5A02);
        rdsr(s);
        chk("R10 latch cleared at cycle end", s, 8'h00);
    endtask

    task automatic t_write_protect();
        logic [7:0]  s;
        logic [31:0] r;
        cmd1(8'h06);
        wp_n = 1'b0; wt(10); wp_n = 1'b1; wt(10);
        rdsr(s);
        chk("R13 protect pin clears latch", s, 8'h00);
        clean_write(9'h030, 8'h01);
        cmd1(8'h06);
        mem_write(9'h030, 1, {8'hF0, 24'h0}, 0, 1);
        wait_wc();
        mem_read(9'h030, 1, r);
        chk("R13 protect pulse aborts pending write", r[31:24], 8'h01);
        cmd1(8'h06);
        mem_write(9'h030, 1, {8'hC3, 24'h0}, 0, 0);
        wp_n = 1'b0; wt(50); wp_n = 1'b1;
        wait_wc();
        mem_read(9'h030, 1, r);
        chk("R13 protect pin ignored once cycle runs", r[31:24], 8'hC3);
    endtask

    task automatic t_block_protect();
        logic [7:0]  s, d;
        logic [31:0] r;
        clean_write(9'h180, 8'h11);
        clean_write(9'h17F, 8'h00);
        cmd1(8'h06);
        open_s(); xfer(8'h01, d); xfer(8'h24, d); close_s();
        wait_wc();
        chk("R12 watchdog field exported", wdog_mode, 2'b10);
        rdsr(s);
        chk("R12 status after status write", s, 8'h24);
        cmd1(8'h06);
        mem_write(9'h180, 1, {8'hEE, 24'h0}, 0, 0);
        wait_wc();
        cmd1(8'h06);
        mem_write(9'h17F, 1, {8'h99, 24'h0}, 0, 0);
        wait_wc();
        mem_read(9'h17F, 2, r);
        chk("R11 top quarter locked, below writable, reads open", r[31:16], 16'h9911);
    endtask

    initial begin
        wt(150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset_and_powerup();
        t_latch();
        t_no_latch();
        t_page_wrap();
        t_bad_length();
        t_high_bit_and_stream();
        t_busy_masking();
        t_write_protect();
        t_block_protect();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule